// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block decides, one clock cycle at a time, whether a new task may be launched into a shared static pipeline without two tasks claiming the same stage in the same cycle. The forbidden launch distances are given as a parameter vector. Bit k-1 of that vector (the bit called C_k) is 1 when launching two tasks k cycles apart would collide. The controller keeps a collision state that starts at this vector. It counts the cycles since the previous launch and raises a grant only when a request is present and the current distance is allowed.

After a launch at distance k, the stored collision state becomes the old state shifted right by k places, ORed with the parameter vector. Internally the state shifts right by one place on every cycle between launches, so its least significant bit always tells whether the current distance is forbidden. A requester that holds its request high is admitted at the earliest permitted distance each time, which gives the greedy launch schedule. The first request after reset is admitted at once, because the pipeline is empty at that point.

Top module: `pipe_admit`

## Requirements
- R1: While reset is high and on the first cycle after it, `state` equals the parameter vector `CV` (bit k-1 = C_k) and `latency` is 0.
- R2: With `latency` equal to 0 (no launch since reset), a request is granted in the same cycle, and the next `state` is `CV`.
- R3: `grant` is never high in a cycle where `req` is low, even when the current distance is permitted.
- R4: For 1 <= k <= N, a request at distance k is refused when bit C_k of the collision state left by the previous launch is 1, and granted when that bit is 0.
- R5: A grant at distance k (1 <= k <= N) makes the next `state` equal to the previous launch's state shifted right by k, ORed with `CV`. For `CV` = 1011010, distance 1 gives 1111111, distance 3 gives 1011011, and distance 3 or 6 from 1011011 gives 1011011.
- R6: `latency` becomes 1 on the cycle after a grant, rises by one each cycle without a grant, and saturates at N+1.
- R7: A request at any distance greater than N (shown as `latency` = N+1) is granted, and the next `state` is `CV`.
- R8: A request held high from reset is granted at the smallest permitted distance each time. This gives launch distances 0,1,8,1,8,1 for `CV` = 1011010 (N=7), and 0,1,1,6,1,1 for `CV` = 11100 (N=5).
- R9: Between grants, once a launch has happened, `state` shifts right by one place per cycle, so at distance k it shows the last launch's state shifted right by k-1.
- R10: Before the first grant after reset, `state` holds `CV` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | A task is waiting to be launched |
| grant | output | 1 | Launch allowed this cycle (combinational from `req`) |
| state | output | N | Working collision state; bit 0 is the verdict for the current distance |
| latency | output | $clog2(N+2) | Cycles since the last launch; 0 before the first, saturating at N+1 |

## Verification
A per-cycle vector walk on the 7-bit vector 1011010 uses requests at chosen distances. Requests at distances 2 and 4 show that forbidden bits are honoured. Requests at distances 3 and 6 reach the stable state 1011011, and distance 1 drives the state to all ones, which tells the shift-and-OR update apart from a plain busy flag. Long idle stretches exercise counter saturation and the return to the vector. A held request on both the 7-bit and the 5-bit vector checks the greedy distance sequence, which differs between the two. A mid-run reset and requests dropped at permitted distances cover the remaining cases.

// File: rtl/pipe_admit.sv
module pipe_admit #(
  parameter int N = 7,
  parameter logic [N-1:0] CV = 7'b1011010
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  output logic                    grant,
  output logic [N-1:0]            state,
  output logic [$clog2(N+2)-1:0]  latency
);
  localparam int W = $clog2(N+2);
  localparam logic [W-1:0] LSAT = W'(N + 1);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [N-1:0] w;
  logic [W-1:0] cnt;
  logic idle, clear;

  assign idle    = (cnt == '0);
  assign clear   = idle || (cnt == LSAT) || !w[0];
  assign grant   = req && clear;
  assign state   = w;
  assign latency = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      w   <= CV;
      cnt <= '0;
    end else if (grant) begin
      w   <= (idle ? '0 : (w >> 1)) | CV;
      cnt <= ONE;
    end else if (!idle) begin
      w <= w >> 1;
      if (cnt != LSAT) cnt <= cnt + ONE;
    end
  end

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == CV) && (latency == '0)); // R1
  AST_FIRST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (grant && latency == '0) |=> state == CV); // R2
  AST_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (grant && latency != '0) |=> state == (($past(state) >> 1) | CV)); // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    grant |=> latency == ONE); // R6
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (!grant && latency != '0 && latency != LSAT) |=> latency == $past(latency) + ONE); // R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!grant && latency == LSAT) |=> latency == LSAT); // R6
  AST_LONG_GAP: assert property (@(posedge clk) disable iff (rst)
    (req && latency == LSAT) |=> state == CV); // R7
  AST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!grant && latency != '0) |=> state == ($past(state) >> 1)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!grant && latency == '0) |=> $stable(state)); // R10
endmodule

// File: tb/test_pipe_admit.sv
module test_pipe_admit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic req_b = 1'b0;
  logic grant, grant_b;
  logic [6:0] state;
  logic [4:0] state_b;
  logic [3:0] latency;
  logic [2:0] latency_b;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pipe_admit #(.N(7), .CV(7'b1011010)) i_pipe_admit (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .state(state), .latency(latency));

  pipe_admit #(.N(5), .CV(5'b11100)) i_pipe_admit_5 (
    .clk(clk), .rst(rst), .req(req_b), .grant(grant_b), .state(state_b), .latency(latency_b));

  // {req, expected grant, expected state, expected latency} for one cycle
  localparam logic [12:0] VEC [0:34] = '{
    {1'b0, 1'b0, 7'b1011010, 4'd0},
    {1'b0, 1'b0, 7'b1011010, 4'd0},
    {1'b1, 1'b1, 7'b1011010, 4'd0},
    {1'b1, 1'b1, 7'b1011010, 4'd1},
    {1'b1, 1'b0, 7'b1111111, 4'd1},
    {1'b1, 1'b0, 7'b0111111, 4'd2},
    {1'b1, 1'b0, 7'b0011111, 4'd3},
    {1'b1, 1'b0, 7'b0001111, 4'd4},
    {1'b1, 1'b0, 7'b0000111, 4'd5},
    {1'b1, 1'b0, 7'b0000011, 4'd6},
    {1'b1, 1'b0, 7'b0000001, 4'd7},
    {1'b1, 1'b1, 7'b0000000, 4'd8},
    {1'b0, 1'b0, 7'b1011010, 4'd1},
    {1'b1, 1'b0, 7'b0101101, 4'd2},
    {1'b1, 1'b1, 7'b0010110, 4'd3},
    {1'b0, 1'b0, 7'b1011011, 4'd1},
    {1'b0, 1'b0, 7'b0101101, 4'd2},
    {1'b1, 1'b1, 7'b0010110, 4'd3},
    {1'b0, 1'b0, 7'b1011011, 4'd1},
    {1'b0, 1'b0, 7'b0101101, 4'd2},
    {1'b0, 1'b0, 7'b0010110, 4'd3},
    {1'b1, 1'b0, 7'b0001011, 4'd4},
    {1'b1, 1'b0, 7'b0000101, 4'd5},
    {1'b1, 1'b1, 7'b0000010, 4'd6},
    {1'b0, 1'b0, 7'b1011011, 4'd1},
    {1'b0, 1'b0, 7'b0101101, 4'd2},
    {1'b0, 1'b0, 7'b0010110, 4'd3},
    {1'b0, 1'b0, 7'b0001011, 4'd4},
    {1'b0, 1'b0, 7'b0000101, 4'd5},
    {1'b0, 1'b0, 7'b0000010, 4'd6},
    {1'b0, 1'b0, 7'b0000001, 4'd7},
    {1'b0, 1'b0, 7'b0000000, 4'd8},
    {1'b0, 1'b0, 7'b0000000, 4'd8},
    {1'b1, 1'b1, 7'b0000000, 4'd8},
    {1'b0, 1'b0, 7'b1011010, 4'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = 1'b0;
    req_b = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int lat7 [0:5] = '{0, 1, 8, 1, 8, 1};
    int lat5 [0:5] = '{0, 1, 1, 6, 1, 1};
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    #1;
    check(state == 7'b1011010, "R1 state after reset", state, 7'b1011010);
    check(latency == 4'd0, "R1 latency after reset", latency, 0);
    @(negedge clk);

    for (int i = 0; i < 35; i++) begin
      req = VEC[i][12];
      #1;
      check(grant == VEC[i][11], $sformatf("R4 grant row %0d", i), grant, VEC[i][11]);
      check(state == VEC[i][10:4], $sformatf("R5 R9 state row %0d", i), state, VEC[i][10:4]);
      check(latency == VEC[i][3:0], $sformatf("R6 latency row %0d", i), latency, VEC[i][3:0]);
      @(negedge clk);
    end

    // R3: permitted distance but no request
    req = 1'b0;
    repeat (9) @(negedge clk);
    #1;
    check(latency == 4'd8, "R3 latency saturated", latency, 8);
    check(grant == 1'b0, "R3 no grant without req", grant, 0);

    // R1: reset mid-run after a launch
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    do_reset();
    #1;
    check(state == 7'b1011010, "R1 state after mid reset", state, 7'b1011010);
    check(latency == 4'd0, "R1 latency after mid reset", latency, 0);

    // R10: idle before first launch keeps the vector
    repeat (4) @(negedge clk);
    #1;
    check(state == 7'b1011010, "R10 state held while idle", state, 7'b1011010);
    check(state_b == 5'b11100, "R10 state held while idle (5-bit)", state_b, 5'b11100);

    // R2: first request granted at once
    @(negedge clk);
    req = 1'b1;
    #1;
    check(grant == 1'b1, "R2 first request granted", grant, 1);
    @(negedge clk);
    req = 1'b0;
    #1;
    check(state == 7'b1011010, "R2 state after first launch", state, 7'b1011010);

    // R8: held request gives the greedy schedule on both vectors
    do_reset();
    req = 1'b1;
    req_b = 1'b1;
    n = 0;
    for (int c = 0; c < 20; c++) begin
      #1;
      if (grant) begin
        if (n < 6) check(int'(latency) == lat7[n], $sformatf("R8 greedy distance %0d (7-bit)", n), latency, lat7[n]);
        n++;
      end
      @(negedge clk);
    end
    check(n == 6, "R8 grant count (7-bit)", n, 6);

    do_reset();
    req_b = 1'b1;
    n = 0;
    for (int c = 0; c < 15; c++) begin
      #1;
      if (grant_b) begin
        if (n < 6) check(int'(latency_b) == lat5[n], $sformatf("R8 greedy distance %0d (5-bit)", n), latency_b, lat5[n]);
        if (n == 2) begin
          @(posedge clk);
          #1;
          check(state_b == 5'b11111, "R5 state 11111 after 1,1 (5-bit)", state_b, 5'b11111);
          n++;
          @(negedge clk);
          continue;
        end
        n++;
      end
      @(negedge clk);
    end
    check(n == 6, "R8 grant count (5-bit)", n, 6);
    req_b = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule